// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Processor Stall Handshake

This block keeps the contents of a DRAM alive by scheduling row refreshes from its own interval timer and row counter. When a refresh falls due it asks the processor to stop by raising a stall request. It waits until the processor acknowledges, then pulses a refresh strobe together with a row address for an external memory sequencer. When the work is done it lets the processor run again.

Two scheduling modes share one row counter. In spread mode one row is refreshed per slot, and a slot is the retention period divided by the row count. In block mode every row is refreshed back to back inside a single stall window, once per retention period. The timer reload values come from the clock frequency, the retention period and the row count at elaboration. Due refreshes that cannot start yet are queued in a small saturating counter. A sticky error flag reports that the queue has lost one.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the timer, the row counter (`ref_row` = 0), the queue and `pend_ovf`, and drives `stall_req` and `ref_strobe` low.
- R2: When a refresh job starts, `stall_req` goes high and stays high for as long as `stall_ack` has not been seen high.
- R3: `ref_strobe` is never high in a job until `stall_ack` has been sampled high while `stall_req` was high.
- R4: Each row refresh drives `ref_strobe` high for exactly STROBE_CYCLES consecutive cycles, and `ref_row` is stable over those cycles. `stall_req` is high throughout.
- R5: `stall_req` falls in the same cycle in which the final strobe of a job ends.
- R6: With `mode_burst` = 0, a job falls due every PERIOD_CYC/ROWS cycles and refreshes one row. PERIOD_CYC = CLK_HZ*PERIOD_US/10^6. With a prompt acknowledge, successive rises of `stall_req` are exactly that many cycles apart.
- R7: The row counter advances by one after every row refresh and wraps from ROWS-1 to 0.
- R8: With `mode_burst` = 1, a job falls due every PERIOD_CYC cycles. Inside one stall window it refreshes ROWS consecutive rows, with one strobe-low cycle between strobes.
- R9: Jobs that fall due while another is waiting or running are queued, up to PEND_MAX of them. Each queued job later runs as a job of its own.
- R10: A job that falls due while PEND_MAX jobs are already queued sets `pend_ovf`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_burst | input | 1 | 0: one row per slot; 1: all rows once per period. Sampled when a job starts |
| stall_ack | input | 1 | The processor confirms that it is stalled |
| stall_req | output | 1 | Request to stall the processor |
| ref_strobe | output | 1 | Refresh command for the memory sequencer |
| ref_row | output | $clog2(ROWS) | Row to refresh while `ref_strobe` is high |
| pend_ovf | output | 1 | Sticky flag: a due refresh was lost |

## Verification
Several acknowledge patterns are applied.

- **Prompt acknowledge.** This exposes the exact slot spacing, the strobe width and the point where the stall is released. Each mode has its own spacing, so the two modes are told apart by spacing and by the number of strobes in each stall window.
- **Acknowledge held off for just over three slots.** The queue should then drain as four back-to-back jobs with no error. This separates correct queuing from dropped or merged jobs.
- **Acknowledge held off for just over four slots.** This checks that the error flag is raised, that it survives later traffic and that only reset clears it.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler.
package refresh_pkg;

    // Job sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no job, processor runs
        ST_REQ  = 2'd1,   // stall requested, waiting for acknowledge
        ST_RUN  = 2'd2,   // strobe high on current row
        ST_GAP  = 2'd3    // one idle cycle between rows of a block job
    } ref_state_t;

endpackage

// File: rtl/refresh_timer.sv
// Interval timer: emits a one-cycle tick every DIST_CYC cycles (spread
// mode) or BURST_CYC cycles (block mode). Assumes both limits are >= 2.
// If the mode changes, the current count is compared against the new limit.
module refresh_timer #(
    parameter int TMR_W     = 24,
    parameter int DIST_CYC  = 781,
    parameter int BURST_CYC = 6400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_burst,
    output logic tick
);
    localparam logic [TMR_W-1:0] DIST_LAST  = TMR_W'(DIST_CYC - 1);
    localparam logic [TMR_W-1:0] BURST_LAST = TMR_W'(BURST_CYC - 1);

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] last;

    // Select the terminal count of the active mode
    always_comb begin
        last = mode_burst ? BURST_LAST : DIST_LAST;
        tick = (cnt_q >= last);
    end

    // Count up and reload to zero on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/refresh_pending.sv
// Saturating queue of due jobs. A tick adds one and a take removes one.
// A tick that finds the queue full sets a sticky overflow flag.
// Assumes take is only raised while has_work is high.
module refresh_pending #(
    parameter int PEND_MAX = 3,
    parameter int PEND_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic has_work,
    output logic ovf
);
    localparam logic [PEND_W-1:0] FULL = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] cnt_q;

    // Expose whether any job is waiting
    always_comb has_work = (cnt_q != '0);

    // Update the count and the overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            case ({tick, take})
                2'b10: begin
                    if (cnt_q == FULL) ovf   <= 1'b1;
                    else               cnt_q <= cnt_q + 1'b1;
                end
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/refresh_fsm.sv
// Job sequencer and row counter. It takes one job from the queue, requests
// a stall, waits for the acknowledge, and then strobes one row (spread
// mode) or ROWS rows (block mode) before releasing the stall.
module refresh_fsm
    import refresh_pkg::*;
#(
    parameter int ROWS          = 8192,
    parameter int ROW_W         = 13,
    parameter int STROBE_CYCLES = 4,
    parameter int STB_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_burst,
    input  logic             has_work,
    input  logic             stall_ack,
    output logic             take,
    output logic             stall_req,
    output logic             ref_strobe,
    output logic [ROW_W-1:0] ref_row
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [STB_W-1:0] STB_LAST = STB_W'(STROBE_CYCLES - 1);
    localparam logic [ROW_W:0]   ALL_ROWS = (ROW_W + 1)'(ROWS);

    ref_state_t       state_q;
    logic [STB_W-1:0] stb_q;
    logic [ROW_W:0]   left_q;
    logic [ROW_W-1:0] row_q;

    // Decode the outputs from the state
    always_comb begin
        take       = (state_q == ST_IDLE) && has_work;
        stall_req  = (state_q != ST_IDLE);
        ref_strobe = (state_q == ST_RUN);
        ref_row    = row_q;
    end

    // Step through request, strobe and gap, and advance the row counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stb_q   <= '0;
            left_q  <= '0;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (has_work) begin
                    state_q <= ST_REQ;
                    left_q  <= mode_burst ? ALL_ROWS : (ROW_W + 1)'(1);
                end
                ST_REQ: if (stall_ack) begin
                    state_q <= ST_RUN;
                    stb_q   <= '0;
                end
                ST_RUN: begin
                    if (stb_q == STB_LAST) begin
                        row_q   <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q > (ROW_W + 1)'(1)) ? ST_GAP : ST_IDLE;
                    end else begin
                        stb_q <= stb_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    stb_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the refresh scheduler. It derives the timer limits from the clock
// rate, the retention period and the row count, and wires the timer, the
// queue and the sequencer together. Assumes ROWS >= 2 and that
// CLK_HZ*PERIOD_US/1e6 is at least 2*ROWS.
module dram_refresh_sched #(
    parameter int CLK_HZ        = 100_000_000,
    parameter int PERIOD_US     = 64_000,
    parameter int ROWS          = 8192,
    parameter int STROBE_CYCLES = 4,
    parameter int PEND_MAX      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_burst,
    input  logic                     stall_ack,
    output logic                     stall_req,
    output logic                     ref_strobe,
    output logic [$clog2(ROWS)-1:0]  ref_row,
    output logic                     pend_ovf
);
    localparam longint PERIOD_CYC = (longint'(CLK_HZ) * longint'(PERIOD_US)) / 64'd1_000_000;
    localparam int     BURST_CYC  = int'(PERIOD_CYC);
    localparam int     DIST_CYC   = BURST_CYC / ROWS;
    localparam int     TMR_W      = $clog2(BURST_CYC + 1);
    localparam int     ROW_W      = $clog2(ROWS);
    localparam int     PEND_W     = $clog2(PEND_MAX + 1);
    localparam int     STB_W      = $clog2(STROBE_CYCLES + 1);

    logic tick;
    logic take;
    logic has_work;

    refresh_timer #(
        .TMR_W(TMR_W), .DIST_CYC(DIST_CYC), .BURST_CYC(BURST_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .tick(tick)
    );

    refresh_pending #(
        .PEND_MAX(PEND_MAX), .PEND_W(PEND_W)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
        .has_work(has_work), .ovf(pend_ovf)
    );

    refresh_fsm #(
        .ROWS(ROWS), .ROW_W(ROW_W), .STROBE_CYCLES(STROBE_CYCLES), .STB_W(STB_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .has_work(has_work),
        .stall_ack(stall_ack), .take(take), .stall_req(stall_req),
        .ref_strobe(ref_strobe), .ref_row(ref_row)
    );
endmodule

// File: rtl/refresh_sched_checker.sv
// Protocol checker for dram_refresh_sched, bound to every instance of it.
module refresh_sched_checker #(
    parameter int ROWS = 8192
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stall_ack,
    input logic                     stall_req,
    input logic                     ref_strobe,
    input logic [$clog2(ROWS)-1:0]  ref_row,
    input logic                     pend_ovf
);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic granted;

    // Record that the acknowledge has been seen in the current stall window
    always_ff @(posedge clk) begin
        if (!rst_n)          granted <= 1'b0;
        else if (!stall_req) granted <= 1'b0;
        else if (stall_ack)  granted <= 1'b1;
    end

    // R1: reset clears the outputs and the flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!stall_req && !ref_strobe && !pend_ovf && ref_row == '0));

    // R2: the request holds until it is granted
    a_r2_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && !granted) |=> stall_req);

    // R3: no strobe before the grant
    a_r3_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> granted);

    // R4: a strobe only occurs under a stall
    a_r4_strobe_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> stall_req);

    // R4: the row only changes as a strobe ends
    a_r4_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |-> $fell(ref_strobe));

    // R7: the row steps by one and wraps
    a_r7_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |->
            (ref_row == (($past(ref_row) == ROW_LAST) ? '0 : $past(ref_row) + 1'b1)));

    // R10: the overflow flag is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ovf |=> pend_ovf);
endmodule

bind dram_refresh_sched refresh_sched_checker #(.ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall_ack(stall_ack), .stall_req(stall_req),
    .ref_strobe(ref_strobe), .ref_row(ref_row), .pend_ovf(pend_ovf)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
// Directed bench. Parameters: 1 MHz nominal, 400 us period and 4 rows, so
// PERIOD_CYC = 400 and the slot is 100 cycles. The strobe lasts 4 cycles.
module sim_dram_refresh_sched;
    localparam int ROWS   = 4;
    localparam int STB    = 4;
    localparam int PERIOD = 400;
    localparam int SLOT   = PERIOD / ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_burst = 1'b0;
    logic       stall_ack = 1'b0;
    logic       auto_ack = 1'b0;
    logic       stall_req, ref_strobe, pend_ovf;
    logic [1:0] ref_row;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    // Cycle counter and the processor model's acknowledge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        stall_ack <= auto_ack & stall_req;
    end

    dram_refresh_sched #(
        .CLK_HZ(1_000_000), .PERIOD_US(PERIOD), .ROWS(ROWS),
        .STROBE_CYCLES(STB), .PEND_MAX(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .stall_ack(stall_ack),
        .stall_req(stall_req), .ref_strobe(ref_strobe), .ref_row(ref_row),
        .pend_ovf(pend_ovf)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        auto_ack   = 1'b0;
        mode_burst = mode;
        rst_n      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_stall_rise(output int t);
        int n = 0;
        while (!stall_req && n < 2000) begin @(negedge clk); n++; end
        t = cyc;
    endtask

    task automatic wait_stall_fall();
        int n = 0;
        while (stall_req && n < 2000) begin @(negedge clk); n++; end
    endtask

    // R1: outputs after reset, including a reset in the middle of a job
    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk);
        check_eq("R1", "stall_req after reset", int'(stall_req), 0);
        check_eq("R1", "ref_strobe after reset", int'(ref_strobe), 0);
        check_eq("R1", "ref_row after reset", int'(ref_row), 0);
        check_eq("R1", "pend_ovf after reset", int'(pend_ovf), 0);
    endtask

    // R2, R3, R4: hold the acknowledge off, then grant it
    task automatic t_handshake();
        int t, bad, w, n;
        do_reset(1'b0);
        wait_stall_rise(t);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!stall_req || ref_strobe) bad++;
        end
        check_eq("R2", "cycles with stall dropped or strobe early", bad, 0);
        auto_ack = 1'b1;
        n = 0;
        while (!ref_strobe && n < 20) begin @(negedge clk); n++; end
        check_eq("R3", "strobe after acknowledge", int'(ref_strobe), 1);
        w = 0;
        while (ref_strobe && w < 20) begin @(negedge clk); w++; end
        check_eq("R4", "strobe width", w, STB);
    endtask

    // R4, R5, R6, R7: spread mode with a prompt acknowledge
    task automatic t_spread();
        int t, prev, w, row;
        do_reset(1'b0);
        auto_ack = 1'b1;
        prev = 0;
        for (int j = 0; j < 5; j++) begin
            wait_stall_rise(t);
            if (j > 0) check_eq("R6", "spacing of stall requests", t - prev, SLOT);
            prev = t;
            while (!ref_strobe) @(negedge clk);
            row = int'(ref_row);
            w = 0;
            while (ref_strobe && w < 20) begin
                if (int'(ref_row) != row) w = 100;
                @(negedge clk); w++;
            end
            check_eq("R4", "strobe width with stable row", w, STB);
            check_eq("R5", "stall released with last strobe", int'(stall_req), 0);
            check_eq("R7", "row of job", row, j % ROWS);
        end
    endtask

    // R8: block mode refreshes all rows in one window per period
    task automatic t_block();
        int t, prev, nstb, gaps, rowbad;
        logic pstb;
        do_reset(1'b1);
        auto_ack = 1'b1;
        prev = 0;
        for (int p = 0; p < 2; p++) begin
            wait_stall_rise(t);
            if (p > 0) check_eq("R8", "block period", t - prev, PERIOD);
            prev = t;
            nstb = 0; gaps = 0; rowbad = 0; pstb = 1'b0;
            while (stall_req) begin
                if (ref_strobe && !pstb) begin
                    if (int'(ref_row) != nstb % ROWS) rowbad++;
                    nstb++;
                end
                if (!ref_strobe && nstb > 0) gaps++;
                pstb = ref_strobe;
                @(negedge clk);
            end
            check_eq("R8", "strobes in one window", nstb, ROWS);
            check_eq("R8", "gap cycles between strobes", gaps, ROWS - 1);
            check_eq("R7", "rows out of order in block", rowbad, 0);
        end
    endtask

    // R9: three queued jobs plus the waiting one all run after the grant
    task automatic t_queue();
        int t, rises;
        logic pstb;
        do_reset(1'b0);
        wait_stall_rise(t);
        repeat (350) @(negedge clk);
        check_eq("R9", "no overflow at three queued", int'(pend_ovf), 0);
        auto_ack = 1'b1;
        rises = 0; pstb = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_strobe && !pstb) rises++;
            pstb = ref_strobe;
        end
        check_eq("R9", "jobs drained after grant", rises, 4);
    endtask

    // R10, R1: the fourth queued job overflows; only reset clears the flag
    task automatic t_overflow();
        int t;
        do_reset(1'b0);
        wait_stall_rise(t);
        repeat (460) @(negedge clk);
        check_eq("R10", "overflow flag set", int'(pend_ovf), 1);
        auto_ack = 1'b1;
        repeat (150) @(negedge clk);
        check_eq("R10", "overflow flag sticky", int'(pend_ovf), 1);
        auto_ack = 1'b0;
        repeat (120) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1", "stall cleared by reset mid-job", int'(stall_req), 0);
        check_eq("R1", "overflow cleared by reset", int'(pend_ovf), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_handshake();
        t_spread();
        t_block();
        t_queue();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule